// File: doc/BRIEF.md
# Host Buffer Write Pointer Port

This block sits between a local processor's register bus and an on-chip packet buffer. The processor fills the buffer through a few byte-wide registers. Two registers hold the low and high bytes of a 16-bit byte address. A data register stores the word presented on the bus at that address whenever it is written. After each data write the address advances by the processor bus width: one, two or four bytes.

A control bit picks who supplies the address. In manual mode the processor loads the pointer itself. In this mode the pointer falls back to zero whenever an increment carries its low 14 bits past the top of a 16K-byte window. In automatic mode an internal transmit pointer supplies the address instead, and the processor's address registers are frozen. A pair of byte registers holds the length of the packet to be sent.

The buffer is modelled as a byte array with 2^MEM_AW entries, indexed by the low bits of the byte address. A read port on the buffer lets the surrounding logic, or a bench, see its contents.

Top module: `hwp_host_wport`

## Requirements
- R1: After an active-low reset, the following all read as zero: the manual pointer, the transmit pointer, both length bytes and the mode bit. The active write address `wr_addr` stays unchanged in any cycle without a register write.
- R2: A write with `reg_sel`=5 stores N bytes of `reg_wdata` at the active address and the N-1 following addresses, modulo 64K. The bytes go least significant first. N is the bus step. The buffer location used is the low MEM_AW bits of each address.
- R3: The bus step is 1 for `bus_mode`=0, 2 for `bus_mode`=1, 4 for `bus_mode`=2, and 1 for `bus_mode`=3. In manual mode, a data write advances the pointer by this step.
- R4: In manual mode, a data write sets the pointer to 0000h when the low 14 bits of the pointer plus the step reach or exceed 4000h.
- R5: In manual mode, a write with `reg_sel`=0 loads pointer bits 7:0 from `reg_wdata[7:0]`, and `reg_sel`=1 loads bits 15:8. The next data write uses the new value.
- R6: With `reg_sel`=0 or 1, `reg_rdata` shows the low or high byte of the live manual pointer, including increments made since the last load.
- R7: When control bit 7 is set, `wr_addr` is the transmit pointer. Each data write advances it by the step, modulo 64K, with no 16K fall-back.
- R8: While control bit 7 is set, writes to `reg_sel`=0 or 1 leave the manual pointer unchanged.
- R9: `reg_sel`=4 is the control register. Bit 7 is the read/write mode bit. Bit 0 is read-only and reads 1 when `bus_mode` is 0 or 3, and 0 otherwise. All other bits read 0.
- R10: `reg_sel`=2 and 3 are the read/write length low and high bytes. They change only when written. Selects 5, 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mode | input | 2 | Processor bus width strap |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| wr_addr | output | 16 | Active buffer write address |
| mem_raddr | input | MEM_AW | Buffer read address |
| mem_rdata | output | 8 | Buffer read data |

## Verification
The assertions check on every clock that the active address moves by the step or falls back to zero at the 16K edge in manual mode, and moves by the step in automatic mode. They also check that the address holds when no register write occurs, that frozen pointer writes in automatic mode leave the manual pointer untouched, that the width flag follows the strap, and that the length registers keep their value unless written. Several behaviours can only be shown by the bench's scenarios, which replay writes against an independent model: the byte order and aliasing of data in the buffer, the carry of a multi-byte write across the 16K edge, the return to the held manual pointer after leaving automatic mode, and the live readback of the pointer bytes.

// File: rtl/hwp_pkg.sv
package hwp_pkg;
  localparam int PTR_W = 16;

  typedef enum logic [2:0] {
    SEL_PTR_LO = 3'd0,
    SEL_PTR_HI = 3'd1,
    SEL_LEN_LO = 3'd2,
    SEL_LEN_HI = 3'd3,
    SEL_CTRL   = 3'd4,
    SEL_DATA   = 3'd5
  } sel_e;

  typedef enum logic [1:0] {
    BUS_8   = 2'd0,
    BUS_16  = 2'd1,
    BUS_32  = 2'd2,
    BUS_RSV = 2'd3
  } bus_e;

  function automatic logic [2:0] step_of(input logic [1:0] mode);
    case (mode)
      BUS_16:  return 3'd2;
      BUS_32:  return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  // Manual-mode advance: collapse to zero when the window offset overflows.
  function automatic logic [PTR_W-1:0] manual_next(input logic [PTR_W-1:0] p,
                                                   input logic [2:0]       s,
                                                   input logic [PTR_W-1:0] mask);
    logic [PTR_W:0] low;
    low = {1'b0, p & mask} + {{(PTR_W-2){1'b0}}, s};
    if (low > {1'b0, mask}) return '0;
    return p + {{(PTR_W-3){1'b0}}, s};
  endfunction
endpackage

// File: rtl/hwp_ptr_unit.sv
module hwp_ptr_unit
  import hwp_pkg::*;
#(
  parameter int BOUND_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_mode,
  input  logic [2:0]       step,
  input  logic             cmd_fire,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [7:0]       wbyte,
  output logic [PTR_W-1:0] man_ptr,
  output logic [PTR_W-1:0] tx_ptr,
  output logic [PTR_W-1:0] act_ptr
);
  localparam logic [PTR_W-1:0] BOUND_MASK = PTR_W'((1 << BOUND_W) - 1);

  logic lo_load, hi_load, man_adv, tx_adv;
  assign lo_load = lo_we & ~auto_mode;
  assign hi_load = hi_we & ~auto_mode;
  assign man_adv = cmd_fire & ~auto_mode;
  assign tx_adv  = cmd_fire & auto_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      man_ptr <= '0;
    end else if (man_adv) begin
      man_ptr <= manual_next(man_ptr, step, BOUND_MASK);
    end else if (lo_load) begin
      man_ptr[7:0] <= wbyte;
    end else if (hi_load) begin
      man_ptr[PTR_W-1:8] <= wbyte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tx_ptr <= '0;
    else if (tx_adv) tx_ptr <= tx_ptr + {{(PTR_W-3){1'b0}}, step};
  end

  assign act_ptr = auto_mode ? tx_ptr : man_ptr;
endmodule

// File: rtl/hwp_buf_mem.sv
module hwp_buf_mem #(
  parameter int MEM_AW = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [15:0]       base,
  input  logic [2:0]        nbytes,
  input  logic [DATA_W-1:0] wdata,
  input  logic [MEM_AW-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int LANES = DATA_W / 8;
  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0]        mem [DEPTH];
  logic [MEM_AW-1:0] lane_addr [LANES];
  logic [LANES-1:0]  lane_en;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [15:0] full_addr;
    assign full_addr    = base + 16'(g);
    assign lane_addr[g] = full_addr[MEM_AW-1:0];
    assign lane_en[g]   = we && (g < int'(nbytes));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (lane_en[i]) mem[lane_addr[i]] <= wdata[8*i +: 8];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/hwp_host_wport.sv
module hwp_host_wport
  import hwp_pkg::*;
#(
  parameter int MEM_AW  = 10,
  parameter int DATA_W  = 32,
  parameter int BOUND_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_mode,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [15:0]       wr_addr,
  input  logic [MEM_AW-1:0] mem_raddr,
  output logic [7:0]        mem_rdata
);
  logic [2:0]       step;
  logic             cmd_fire;
  logic             auto_q;
  logic             narrow_flag;
  logic [7:0]       len_lo_q, len_hi_q;
  logic [PTR_W-1:0] man_ptr, tx_ptr, act_ptr;

  assign step        = step_of(bus_mode);
  assign cmd_fire    = reg_we && (reg_sel == SEL_DATA);
  assign narrow_flag = (step == 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q   <= 1'b0;
      len_lo_q <= '0;
      len_hi_q <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        SEL_LEN_LO: len_lo_q <= reg_wdata[7:0];
        SEL_LEN_HI: len_hi_q <= reg_wdata[7:0];
        SEL_CTRL:   auto_q   <= reg_wdata[7];
        default: ;
      endcase
    end
  end

  hwp_ptr_unit #(.BOUND_W(BOUND_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .auto_mode(auto_q),
    .step     (step),
    .cmd_fire (cmd_fire),
    .lo_we    (reg_we && (reg_sel == SEL_PTR_LO)),
    .hi_we    (reg_we && (reg_sel == SEL_PTR_HI)),
    .wbyte    (reg_wdata[7:0]),
    .man_ptr  (man_ptr),
    .tx_ptr   (tx_ptr),
    .act_ptr  (act_ptr)
  );

  hwp_buf_mem #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (cmd_fire),
    .base  (act_ptr),
    .nbytes(step),
    .wdata (reg_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  always_comb begin
    case (reg_sel)
      SEL_PTR_LO: reg_rdata = man_ptr[7:0];
      SEL_PTR_HI: reg_rdata = man_ptr[15:8];
      SEL_LEN_LO: reg_rdata = len_lo_q;
      SEL_LEN_HI: reg_rdata = len_hi_q;
      SEL_CTRL:   reg_rdata = {auto_q, 6'b0, narrow_flag};
      default:    reg_rdata = 8'h00;
    endcase
  end

  assign wr_addr = act_ptr;
endmodule

// File: rtl/hwp_host_wport_chk.sv
module hwp_host_wport_chk #(
  parameter int BOUND_W = 14
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bus_mode,
  input logic        reg_we,
  input logic [2:0]  reg_sel,
  input logic [7:0]  reg_rdata,
  input logic [15:0] wr_addr,
  input logic [15:0] man_ptr,
  input logic        auto_q,
  input logic [15:0] len_q
);
  localparam logic [15:0] WIN_MASK = 16'((1 << BOUND_W) - 1);

  logic [15:0] st;
  logic [16:0] win_sum;
  logic        crosses, data_wr, len_wr;

  always_comb begin
    case (bus_mode)
      2'd1:    st = 16'd2;
      2'd2:    st = 16'd4;
      default: st = 16'd1;
    endcase
  end
  assign win_sum = {1'b0, wr_addr & WIN_MASK} + {1'b0, st};
  assign crosses = win_sum > {1'b0, WIN_MASK};
  assign data_wr = reg_we && (reg_sel == 3'd5);
  assign len_wr  = reg_we && (reg_sel == 3'd2 || reg_sel == 3'd3);

  a_r1_addr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(wr_addr));
  a_r3_manual_step: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && !auto_q && !crosses |=> wr_addr == $past(wr_addr) + $past(st));
  a_r4_window_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && !auto_q && crosses |=> wr_addr == 16'h0000);
  a_r7_auto_step: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && auto_q |=> wr_addr == $past(wr_addr) + $past(st));
  a_r8_frozen_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    auto_q && reg_we && (reg_sel == 3'd0 || reg_sel == 3'd1) |=> $stable(man_ptr));
  a_r9_width_flag: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel == 3'd4 |-> reg_rdata[0] == (bus_mode == 2'd0 || bus_mode == 2'd3));
  a_r10_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !len_wr |=> $stable(len_q));
endmodule

bind hwp_host_wport hwp_host_wport_chk #(.BOUND_W(BOUND_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_mode (bus_mode),
  .reg_we   (reg_we),
  .reg_sel  (reg_sel),
  .reg_rdata(reg_rdata),
  .wr_addr  (wr_addr),
  .man_ptr  (man_ptr),
  .auto_q   (auto_q),
  .len_q    ({len_hi_q, len_lo_q})
);

// File: tb/hwp_host_wport_tb.sv
module hwp_host_wport_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW     = 10;
  localparam int DEPTH      = 1 << MEM_AW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        bus_mode = 2'd0;
  logic              reg_we = 1'b0;
  logic [2:0]        reg_sel = 3'd0;
  logic [31:0]       reg_wdata = '0;
  logic [7:0]        reg_rdata;
  logic [15:0]       wr_addr;
  logic [MEM_AW-1:0] mem_raddr = '0;
  logic [7:0]        mem_rdata;

  hwp_host_wport #(.MEM_AW(MEM_AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wr_addr(wr_addr), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // Behavioural reference state
  int m_ptr = 0, m_tx = 0, m_len_lo = 0, m_len_hi = 0;
  bit m_auto = 0;
  logic [7:0] m_mem [int];

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_step();
    if (bus_mode == 2'd1) return 2;
    if (bus_mode == 2'd2) return 4;
    return 1;
  endfunction

  function automatic int m_read(int sel);
    case (sel)
      0: return m_ptr & 'hFF;
      1: return (m_ptr >> 8) & 'hFF;
      2: return m_len_lo;
      3: return m_len_hi;
      4: return (m_auto ? 'h80 : 0) | (m_step() == 1 ? 1 : 0);
      default: return 0;
    endcase
  endfunction

  function automatic string sel_req(int sel);
    case (sel)
      0, 1: return "R6";
      2, 3: return "R10";
      4: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model_apply(int sel, logic [31:0] d);
    int st = m_step();
    case (sel)
      0: if (!m_auto) m_ptr = (m_ptr & 'hFF00) | int'(d[7:0]);
      1: if (!m_auto) m_ptr = (m_ptr & 'h00FF) | (int'(d[7:0]) << 8);
      2: m_len_lo = int'(d[7:0]);
      3: m_len_hi = int'(d[7:0]);
      4: m_auto = d[7];
      5: begin
        int base = m_auto ? m_tx : m_ptr;
        for (int i = 0; i < st; i++)
          m_mem[((base + i) & 'hFFFF) & (DEPTH - 1)] = d[8*i +: 8];
        if (m_auto) m_tx = (m_tx + st) & 'hFFFF;
        else if ((m_ptr & 'h3FFF) + st >= 'h4000) m_ptr = 0;
        else m_ptr = m_ptr + st;
      end
      default: ;
    endcase
  endtask

  // Per-clock comparison against the model, away from the edge
  always @(posedge clk) begin
    #2;
    if (!finished) begin
      check(m_auto ? "R7" : "R3", int'(wr_addr), m_auto ? m_tx : m_ptr);
      check(sel_req(int'(reg_sel)), int'(reg_rdata), m_read(int'(reg_sel)));
    end
  end

  task automatic wr(int sel, logic [31:0] d);
    reg_we = 1'b1;
    reg_sel = 3'(sel);
    reg_wdata = d;
    @(posedge clk);
    model_apply(sel, d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic peek(int sel);
    reg_sel = 3'(sel);
    @(negedge clk);
  endtask

  task automatic check_mem();
    foreach (m_mem[k]) begin
      mem_raddr = MEM_AW'(k);
      #1;
      check("R2", int'(mem_rdata), int'(m_mem[k]));
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values on every register
    for (int s = 0; s < 8; s++) peek(s);

    // R2/R3: 8-bit data writes, step of one
    bus_mode = 2'd0;
    wr(5, 32'h000000AA); wr(5, 32'h000000BB); wr(5, 32'h000000CC);
    peek(0);
    // R5: load both pointer bytes, then 16-bit writes, live readback (R6)
    wr(0, 32'h23); wr(1, 32'h01);
    bus_mode = 2'd1;
    wr(5, 32'h00001122); wr(5, 32'h00003344);
    peek(0); peek(1);

    // R4: 32-bit write ending exactly at the window edge
    bus_mode = 2'd2;
    wr(0, 32'hFC); wr(1, 32'h3F);
    wr(5, 32'hDEADBEEF);
    peek(0); peek(1);
    // R4: 32-bit write straddling the window edge
    wr(0, 32'hFE); wr(1, 32'h3F);
    wr(5, 32'h01020304);
    // R3: plain 32-bit steps in an upper window
    wr(1, 32'h80); wr(0, 32'h00);
    wr(5, 32'h55667788); wr(5, 32'h99AABBCC);
    peek(0); peek(1);
    // R4: 8-bit write on the last byte of a window
    bus_mode = 2'd0;
    wr(0, 32'hFF); wr(1, 32'hBF);
    wr(5, 32'h0000005A);
    peek(1);

    // R10: length registers
    wr(2, 32'h34); wr(3, 32'h12);
    peek(2); peek(3); peek(6); peek(7);

    // Set up a known manual pointer before automatic mode
    wr(0, 32'h10); wr(1, 32'h02);
    // R7/R9: enter automatic mode, read-only flag bit ignored on write
    bus_mode = 2'd2;
    wr(4, 32'h00000081);
    peek(4);
    // R8: pointer writes ignored
    wr(0, 32'h55); wr(1, 32'h66);
    peek(0); peek(1);
    wr(5, 32'hA1A2A3A4);
    bus_mode = 2'd1;
    wr(5, 32'h0000B1B2);
    bus_mode = 2'd0;
    wr(5, 32'h000000C1);
    peek(4);
    // Back to manual: held pointer resumes (R8)
    wr(4, 32'h00000000);
    peek(0); peek(1);
    // R3/R9: reserved bus mode behaves as 8-bit
    bus_mode = 2'd3;
    peek(4);
    wr(5, 32'h000000E7);
    bus_mode = 2'd2;
    peek(4);

    check_mem();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule